// File: doc/BRIEF.md
# Module Reset and Status Sequencer

This block is the small glue controller that sits between a carrier connector and a processor on a plug-in module. An active-low reset request arrives on one of two connector pins and is brought into the clock domain through a two-flop synchronizer. The block turns it into an active-low processor power-on reset and drives the same level back out on the other connector pin, so the carrier sees the module reset too. In the default build a falling edge of the request starts a reset pulse of fixed length, about 1.9 µs. A build-time parameter swaps the roles of the two pins. In the swapped build the reset simply follows the synchronized request for as long as it lasts.

A board status output blinks slowly, with a period of about 1 s at 50 % duty, while the processor reset is held low. The blinking goes on for a hold window of about 30 s after the reset is released. Once that window has run out, the status output is handed to a user signal from the FPGA. Any new reset clears the window, so the full hold period starts again. Two boot-mode straps pass straight through to the processor boot pins. A watchdog trigger output repeats a kick signal from the FPGA while kicking is enabled.

All time constants are derived from a clock-frequency parameter and from time parameters, so a bench can shrink them.

Top module: `modrst_seq`

## Requirements
- R1: In reset and on the first cycle after it, `por_n_o` is 1, the reset output pin's value is 1 and `stat_o` is 0 (blink phase low).
- R2: With `SWAP_PINS`=0, connector pin A is the request input (`conn_a_oe`=0) and pin B is the reset output (`conn_b_oe`=1). With `SWAP_PINS`=1 the roles are reversed. The value on the enabled output pin always equals `por_n_o`.
- R3: With `SWAP_PINS`=0, a falling edge on the request pin drives `por_n_o` low on the third rising clock edge after the pin changes. It stays low for exactly PULSE_CYC = max(1, ceil(CLK_HZ·PULSE_NS/10⁹)) cycles.
- R4: With `SWAP_PINS`=0, a second falling edge during an active pulse does not lengthen it. A request held low after the pulse ends does not start a new pulse.
- R5: With `SWAP_PINS`=1, `por_n_o` equals the request pin delayed by two clock edges, with no limit on how long it stays low.
- R6: While the status output is in its blink mode, it is a square wave with a period of 2·HALF cycles and 50 % duty, where HALF = max(1, CLK_HZ·BLINK_MS/2000). This includes the whole time `por_n_o` is low.
- R7: For WIN_CYC = max(1, CLK_HZ·WINDOW_MS/1000) cycles after `por_n_o` rises, `stat_o` does not depend on `fpga_usr_i`.
- R8: After that window, and while `por_n_o` stays high, `stat_o` equals `fpga_usr_i`.
- R9: A low level on `por_n_o` clears the window, so after each release the full WIN_CYC hold period applies again.
- R10: `boot_sel_o` equals `boot_strap_i` for all four codes: 00 JTAG, 01 QSPI, 11 SD card, 10 unsupported but passed through unchanged.
- R11: `wdi_o` equals `wd_kick_i` when `wd_en_i` is 1, and is 0 when `wd_en_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| conn_a_i | input | 1 | Connector pin A, value read from the pad |
| conn_a_o | output | 1 | Connector pin A, value driven to the pad |
| conn_a_oe | output | 1 | Connector pin A output enable |
| conn_b_i | input | 1 | Connector pin B, value read from the pad |
| conn_b_o | output | 1 | Connector pin B, value driven to the pad |
| conn_b_oe | output | 1 | Connector pin B output enable |
| por_n_o | output | 1 | Processor power-on reset, active low |
| boot_strap_i | input | 2 | Boot-mode straps from the connector |
| boot_sel_o | output | 2 | Boot-mode pins to the processor |
| fpga_usr_i | input | 1 | User status value from the FPGA |
| stat_o | output | 1 | Board status indicator |
| wd_en_i | input | 1 | Watchdog kick enable from the FPGA |
| wd_kick_i | input | 1 | Watchdog kick from the FPGA |
| wdi_o | output | 1 | Trigger to the external watchdog supervisor |

## Verification
The bench builds two copies of the block with CLK_HZ=2,000,000, PULSE_NS=5000, WINDOW_MS=3 and BLINK_MS=1. That gives a 10-cycle reset pulse, a 6000-cycle hold window and a 1000-cycle blink half period. One copy uses each value of SWAP_PINS. These values make it possible to count the exact pulse length, including a retrigger inside the pulse. They also let the bench measure a full blink period and cross the hold window several times within a short run. The swapped copy holds its request low for longer than a blink period, which tests that the pulse limit is gone and that blinking continues under reset.

// File: rtl/modrst_pkg.sv
package modrst_pkg;

  // Cycles covering a time given in nanoseconds, rounded up, never zero.
  function automatic longint ns_to_cycles(input longint clk_hz, input longint ns);
    longint c;
    c = (clk_hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
    return (c < 1) ? 64'd1 : c;
  endfunction

  // Cycles covering a time given in milliseconds, never zero.
  function automatic longint ms_to_cycles(input longint clk_hz, input longint ms);
    longint c;
    c = (clk_hz * ms) / 64'd1000;
    return (c < 1) ? 64'd1 : c;
  endfunction

  // Half of a blink period given in milliseconds, never zero.
  function automatic longint blink_half(input longint clk_hz, input longint ms);
    longint c;
    c = (clk_hz * ms) / 64'd2000;
    return (c < 1) ? 64'd1 : c;
  endfunction

  // Bits needed to hold values 0..n.
  function automatic int cnt_width(input longint n);
    int w;
    w = 1;
    while ((64'd1 << w) <= n) w++;
    return w;
  endfunction

endpackage

// File: rtl/modrst_sync.sv
module modrst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/modrst_pulse.sv
module modrst_pulse #(
  parameter bit      LIMIT     = 1'b1,
  parameter longint  PULSE_CYC = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n_s,
  output logic por_n
);

  localparam int PW = modrst_pkg::cnt_width(PULSE_CYC);
  localparam logic [PW-1:0] PLEN = PW'(PULSE_CYC);

  generate
    if (LIMIT) begin : g_limit
      logic          req_d;
      logic [PW-1:0] cnt;
      logic          active;
      logic          fall_evt;

      assign active   = (cnt != '0);
      assign fall_evt = req_d & ~req_n_s;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          req_d <= 1'b1;
          cnt   <= '0;
        end else begin
          req_d <= req_n_s;
          if (fall_evt && !active) cnt <= PLEN;
          else if (active)         cnt <= cnt - PW'(1);
        end
      end

      assign por_n = ~active;

      a_r4_no_extend: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cnt != PW'(1)) |=> (cnt == $past(cnt) - PW'(1)));
      a_r3_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt <= PLEN));
      a_r3_start_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(por_n) |-> $past(fall_evt));
    end else begin : g_follow
      assign por_n = req_n_s;
    end
  endgenerate

endmodule

// File: rtl/modrst_status.sv
module modrst_status #(
  parameter longint WIN_CYC  = 750,
  parameter longint HALF_CYC = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por_n,
  input  logic usr_i,
  output logic stat_o
);

  localparam int WW = modrst_pkg::cnt_width(WIN_CYC);
  localparam int BW = modrst_pkg::cnt_width(HALF_CYC);
  localparam logic [WW-1:0] WIN_LIM  = WW'(WIN_CYC);
  localparam logic [BW-1:0] HALF_END = BW'(HALF_CYC - 1);

  logic [WW-1:0] win_cnt;
  logic          win_done;
  logic [BW-1:0] bl_cnt;
  logic          blink_ph;

  // Hold window: counts while the processor runs, cleared by any reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                win_cnt <= '0;
    else if (!por_n)           win_cnt <= '0;
    else if (win_cnt != WIN_LIM) win_cnt <= win_cnt + WW'(1);
  end

  assign win_done = (win_cnt == WIN_LIM);

  // Free-running slow blinker.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bl_cnt   <= '0;
      blink_ph <= 1'b0;
    end else if (bl_cnt == HALF_END) begin
      bl_cnt   <= '0;
      blink_ph <= ~blink_ph;
    end else begin
      bl_cnt   <= bl_cnt + BW'(1);
    end
  end

  assign stat_o = (por_n && win_done) ? usr_i : blink_ph;

  a_r7_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    win_cnt <= WIN_LIM);
  a_r9_restart_blink: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(por_n) |=> (stat_o == blink_ph));
  a_r6_blink_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bl_cnt <= HALF_END);

endmodule

// File: rtl/modrst_seq.sv
module modrst_seq #(
  parameter bit     SWAP_PINS = 1'b0,
  parameter longint CLK_HZ    = 25_000_000,
  parameter longint PULSE_NS  = 1900,
  parameter longint WINDOW_MS = 30_000,
  parameter longint BLINK_MS  = 1000,
  parameter int     SYNC_STG  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       conn_a_i,
  output logic       conn_a_o,
  output logic       conn_a_oe,
  input  logic       conn_b_i,
  output logic       conn_b_o,
  output logic       conn_b_oe,
  output logic       por_n_o,
  input  logic [1:0] boot_strap_i,
  output logic [1:0] boot_sel_o,
  input  logic       fpga_usr_i,
  output logic       stat_o,
  input  logic       wd_en_i,
  input  logic       wd_kick_i,
  output logic       wdi_o
);

  localparam longint PULSE_CYC = modrst_pkg::ns_to_cycles(CLK_HZ, PULSE_NS);
  localparam longint WIN_CYC   = modrst_pkg::ms_to_cycles(CLK_HZ, WINDOW_MS);
  localparam longint HALF_CYC  = modrst_pkg::blink_half(CLK_HZ, BLINK_MS);

  logic req_pin;
  logic req_n_s;
  logic por_n;

  assign req_pin = SWAP_PINS ? conn_b_i : conn_a_i;

  modrst_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(req_pin), .q_o(req_n_s)
  );

  modrst_pulse #(.LIMIT(!SWAP_PINS), .PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk(clk), .rst_n(rst_n), .req_n_s(req_n_s), .por_n(por_n)
  );

  modrst_status #(.WIN_CYC(WIN_CYC), .HALF_CYC(HALF_CYC)) u_status (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .usr_i(fpga_usr_i), .stat_o(stat_o)
  );

  assign por_n_o   = por_n;
  assign conn_a_oe = SWAP_PINS;
  assign conn_b_oe = !SWAP_PINS;
  assign conn_a_o  = SWAP_PINS ? por_n : 1'b1;
  assign conn_b_o  = SWAP_PINS ? 1'b1 : por_n;

  assign boot_sel_o = boot_strap_i;
  assign wdi_o      = wd_en_i & wd_kick_i;

  a_r2_echo_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (SWAP_PINS ? conn_a_o : conn_b_o) == por_n_o);

endmodule

// File: tb/modrst_seq_bench.sv
module modrst_seq_bench;

  localparam int P    = 10;    // 2e6 Hz * 5000 ns / 1e9
  localparam int WIN  = 6000;  // 2e6 Hz * 3 ms / 1e3
  localparam int HALF = 1000;  // 2e6 Hz * 1 ms / 2e3

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  // default-variant instance
  logic a_i = 1'b1, b_i = 1'b1, usr = 1'b0, wen = 1'b0, wk = 1'b0;
  logic [1:0] strap = 2'b00;
  logic a_o, a_oe, b_o, b_oe, por, stat, wdi;
  logic [1:0] bsel;

  modrst_seq #(.SWAP_PINS(1'b0), .CLK_HZ(2_000_000), .PULSE_NS(5000),
               .WINDOW_MS(3), .BLINK_MS(1)) u_modrst_seq (
    .clk(clk), .rst_n(rst_n), .conn_a_i(a_i), .conn_a_o(a_o), .conn_a_oe(a_oe),
    .conn_b_i(b_i), .conn_b_o(b_o), .conn_b_oe(b_oe), .por_n_o(por),
    .boot_strap_i(strap), .boot_sel_o(bsel), .fpga_usr_i(usr), .stat_o(stat),
    .wd_en_i(wen), .wd_kick_i(wk), .wdi_o(wdi));

  // swapped-variant instance
  logic sa_i = 1'b1, sb_i = 1'b1, susr = 1'b0;
  logic sa_o, sa_oe, sb_o, sb_oe, spor, sstat, swdi;
  logic [1:0] sbsel;

  modrst_seq #(.SWAP_PINS(1'b1), .CLK_HZ(2_000_000), .PULSE_NS(5000),
               .WINDOW_MS(3), .BLINK_MS(1)) u_modrst_seq_swap (
    .clk(clk), .rst_n(rst_n), .conn_a_i(sa_i), .conn_a_o(sa_o), .conn_a_oe(sa_oe),
    .conn_b_i(sb_i), .conn_b_o(sb_o), .conn_b_oe(sb_oe), .por_n_o(spor),
    .boot_strap_i(strap), .boot_sel_o(sbsel), .fpga_usr_i(susr), .stat_o(sstat),
    .wd_en_i(wen), .wd_kick_i(wk), .wdi_o(swdi));

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R7/R8 helper: does flipping the user input move stat?
  task automatic usr_effect(output bit moved);
    logic s0, s1;
    s0 = stat; usr = ~usr; #1; s1 = stat; usr = ~usr; #1;
    moved = (s0 != s1);
  endtask

  task automatic t_reset_state;
    check(por == 1'b1,  "R1 por", por, 1);
    check(b_o == 1'b1,  "R1 out pin", b_o, 1);
    check(stat == 1'b0, "R1 stat", stat, 0);
    check(a_oe == 1'b0 && b_oe == 1'b1, "R2 default oe", {a_oe, b_oe}, 1);
    check(sa_oe == 1'b1 && sb_oe == 1'b0, "R2 swap oe", {sa_oe, sb_oe}, 2);
    check(spor == 1'b1 && sa_o == 1'b1, "R1 swap por", spor, 1);
  endtask

  task automatic t_blink(input bit use_swap);
    int ones = 0, edges = 0;
    logic prev, cur;
    prev = use_swap ? sstat : stat;
    for (int i = 0; i < 2 * HALF; i++) begin
      @(negedge clk);
      cur = use_swap ? sstat : stat;
      if (cur) ones++;
      if (cur != prev) edges++;
      prev = cur;
    end
    check(ones == HALF, "R6 duty", ones, HALF);
    check(edges == 2, "R6 period", edges, 2);
  endtask

  task automatic t_window_from_reset;
    bit mv;
    usr_effect(mv);
    check(!mv, "R7 user ignored in window", mv, 0);
    cyc(WIN);
    usr = 1'b1; #1;
    check(stat == 1'b1, "R8 follows user 1", stat, 1);
    usr = 1'b0; #1;
    check(stat == 1'b0, "R8 follows user 0", stat, 0);
  endtask

  task automatic t_pulse(input bit retrig);
    int lows = 0, first = 0;
    bit echo_ok = 1'b1;
    @(negedge clk); a_i = 1'b0;
    for (int i = 1; i <= P + 20; i++) begin
      @(negedge clk);
      if (!por) begin lows++; if (first == 0) first = i; end
      if (b_o != por) echo_ok = 1'b0;
      if (retrig && i == 4) a_i = 1'b1;
      if (retrig && i == 6) a_i = 1'b0;
    end
    check(first == 3, retrig ? "R4 start" : "R3 start", first, 3);
    check(lows == P, retrig ? "R4 no extend" : "R3 length", lows, P);
    check(echo_ok, "R2 echo", echo_ok, 1);
    lows = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!por) lows++;
    end
    check(lows == 0, "R4 held low no retrigger", lows, 0);
    a_i = 1'b1;
    cyc(5);
  endtask

  task automatic t_window_restart;
    bit mv;
    usr_effect(mv);
    check(!mv, "R9 window cleared", mv, 0);
    cyc(WIN - 100);
    usr_effect(mv);
    check(!mv, "R7 late in window", mv, 0);
    cyc(150);
    usr_effect(mv);
    check(mv, "R8 after restarted window", mv, 1);
  endtask

  task automatic t_swap_follow;
    int lows = 0, first = 0;
    bit echo_ok = 1'b1;
    @(negedge clk); sb_i = 1'b0;
    for (int i = 1; i <= 300; i++) begin
      @(negedge clk);
      if (!spor) begin lows++; if (first == 0) first = i; end
      if (sa_o != spor) echo_ok = 1'b0;
    end
    check(first == 2, "R5 latency", first, 2);
    check(lows == 299, "R5 no limit", lows, 299);
    check(echo_ok, "R2 swap echo", echo_ok, 1);
    t_blink(1'b1);  // R6 while reset held low
    check(spor == 1'b0, "R5 still low", spor, 0);
    sb_i = 1'b1;
    cyc(1);
    check(spor == 1'b0, "R5 release latency", spor, 0);
    cyc(1);
    check(spor == 1'b1, "R5 released", spor, 1);
  endtask

  task automatic t_boot;
    for (int k = 0; k < 4; k++) begin
      strap = 2'(k); #1;  // 00 JTAG, 01 QSPI, 10 unsupported, 11 SD
      check(bsel == 2'(k) && sbsel == 2'(k), "R10 boot pass", bsel, k);
    end
  endtask

  task automatic t_wdi;
    for (int k = 0; k < 4; k++) begin
      wen = k[1]; wk = k[0]; #1;
      check(wdi == (k == 3) && swdi == (k == 3), "R11 wdi", wdi, (k == 3));
    end
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_blink(1'b0);
    t_window_from_reset();
    t_pulse(1'b0);
    t_window_restart();
    t_pulse(1'b1);
    t_swap_follow();
    t_boot();
    t_wdi();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(150_000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule